// File: doc/BRIEF.md
# Rotating Ones-Complement Checksum Unit

This block forms a 16-bit software checksum over a stream of 16-bit words, one word per clock. Each word is folded into an accumulator with ones-complement arithmetic, so any carry out of the top bit is added back in at the bottom. After each addition the accumulator is rotated left by one bit. That rotation makes the sum depend on word order. The caller chooses which words of a packet go in. The usual choice starts at the word after the checksum field and stops at the last word before the hardware CRC.

A synchronous clear starts a new sum at zero. A finalize strobe captures the result and raises a valid flag. A captured value of all ones is reported as zero, because an all-ones checksum word is reserved to mean "not computed". Given a received checksum word, the block reports whether it matches. A received value of all ones always counts as a match. A parameter selects one of two equivalent datapath forms: add then rotate, or rotate both operands then add. Both forms give bit-identical results.

Top module: `rotsum_unit`

## Requirements
- R1: After reset, `sumValid` is 0, `sumOut` is 0 and the accumulator is 0, so a finalize with no words gives 0x0000.
- R2: For each accepted word the accumulator becomes the left rotate by one bit of the ones-complement sum (end-around carry) of the accumulator and the word.
- R3: A word presented with `wordValid` high is taken on every clock edge, with no stall cycles between back-to-back words.
- R4: When `finalize` is high on an edge, `sumOut` takes the accumulator value including any word accepted on that same edge, and `sumValid` is 1 from that edge on.
- R5: A captured accumulator value of 0xFFFF appears on `sumOut` as 0x0000. While `sumValid` is 1, `sumOut` is never 0xFFFF.
- R6: While `sumValid` is 1, `sumMatch` is 1 when `rxSum` equals `sumOut`. While `sumValid` is 0, `sumMatch` is 0.
- R7: While `sumValid` is 1, `sumMatch` is 1 whenever `rxSum` is 0xFFFF, whatever the computed sum is.
- R8: `clr` high on an edge sets the accumulator to 0, `sumOut` to 0 and `sumValid` to 0, and overrides a `wordValid` or `finalize` presented on the same edge.
- R9: Setting `ROTATE_FIRST` to 1 (rotate accumulator and word, then add) gives the same outputs as setting it to 0 (add, then rotate) for every word sequence.
- R10: `sumOut` changes only on an edge with `finalize` or `clr` high. `sumValid` stays 1 until an edge with `clr` high, or with `wordValid` high and `finalize` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; starts a new sum |
| wordValid | input | 1 | `wordIn` is to be accumulated this cycle |
| wordIn | input | 16 | Data word |
| finalize | input | 1 | Capture the current sum into `sumOut` |
| rxSum | input | 16 | Received checksum word to compare |
| sumOut | output | 16 | Captured checksum (all ones mapped to zero) |
| sumValid | output | 1 | `sumOut` holds a captured result |
| sumMatch | output | 1 | Received checksum agrees, or is marked "not computed" |

## Verification
Directed words exercise the carry path. 0x8001 followed by 0xFFFE produces an end-around carry. 0xFFFF from a zero accumulator produces the all-ones result, which the all-ones-to-zero mapping must replace. A run of random words with random valid, finalize and clear strobes checks order sensitivity, back-to-back acceptance and strobe overlaps against a reference model. Because the model uses a different formulation of the arithmetic, a wrong carry fold or a wrong rotate direction shows up as a mismatch. A second instance built with the rotate-first datapath runs on the same stimulus, and any cycle where the two instances differ separates the two forms. For `rxSum`, the bench drives the true value, a wrong value and 0xFFFF, which separates a real match, a mismatch and the forced match.

// File: rtl/rotsum_pkg.sv
package rotsum_pkg;
  typedef struct packed {
    logic clear;
    logic accumulate;
    logic capture;
  } ctlStrobes_t;
endpackage

// File: rtl/rotsum_ctrl.sv
module rotsum_ctrl
  import rotsum_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clr,
  input  logic        wordValid,
  input  logic        finalize,
  output ctlStrobes_t strobes,
  output logic        sumValid
);
  always_comb begin
    strobes.clear      = clr;
    strobes.accumulate = wordValid & ~clr;
    strobes.capture    = finalize & ~clr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   sumValid <= 1'b0;
    else if (strobes.clear)      sumValid <= 1'b0;
    else if (strobes.capture)    sumValid <= 1'b1;
    else if (strobes.accumulate) sumValid <= 1'b0;
  end
endmodule

// File: rtl/rotsum_datapath.sv
module rotsum_datapath
  import rotsum_pkg::*;
#(
  parameter int W = 16,
  parameter bit ROTATE_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobes_t  strobes,
  input  logic         sumValid,
  input  logic [W-1:0] wordIn,
  input  logic [W-1:0] rxSum,
  output logic [W-1:0] sumOut,
  output logic         sumMatch
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  function automatic logic [W-1:0] ocAdd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W-1:0] + {{(W-1){1'b0}}, s[W]};
  endfunction

  function automatic logic [W-1:0] rotl1(input logic [W-1:0] x);
    return {x[W-2:0], x[W-1]};
  endfunction

  logic [W-1:0] acc, nextAcc, accAfter;

  generate
    if (ROTATE_FIRST) begin : g_rotFirst
      assign nextAcc = ocAdd(rotl1(acc), rotl1(wordIn));
    end else begin : g_addFirst
      assign nextAcc = rotl1(ocAdd(acc, wordIn));
    end
  endgenerate

  assign accAfter = strobes.accumulate ? nextAcc : acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      sumOut <= '0;
    end else if (strobes.clear) begin
      acc    <= '0;
      sumOut <= '0;
    end else begin
      if (strobes.accumulate) acc <= nextAcc;
      if (strobes.capture) sumOut <= (accAfter == ONES) ? '0 : accAfter;
    end
  end

  assign sumMatch = sumValid & ((rxSum == ONES) | (rxSum == sumOut));
endmodule

// File: rtl/rotsum_unit.sv
module rotsum_unit
  import rotsum_pkg::*;
#(
  parameter int W = 16,
  parameter bit ROTATE_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         wordValid,
  input  logic [W-1:0] wordIn,
  input  logic         finalize,
  input  logic [W-1:0] rxSum,
  output logic [W-1:0] sumOut,
  output logic         sumValid,
  output logic         sumMatch
);
  ctlStrobes_t strobes;

  rotsum_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .clr(clr), .wordValid(wordValid),
    .finalize(finalize), .strobes(strobes), .sumValid(sumValid)
  );

  rotsum_datapath #(.W(W), .ROTATE_FIRST(ROTATE_FIRST)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sumValid(sumValid),
    .wordIn(wordIn), .rxSum(rxSum), .sumOut(sumOut), .sumMatch(sumMatch)
  );
endmodule

// File: rtl/rotsum_unit_chk.sv
module rotsum_unit_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rstN,
  input logic         clr,
  input logic         wordValid,
  input logic         finalize,
  input logic [W-1:0] rxSum,
  input logic [W-1:0] sumOut,
  input logic         sumValid,
  input logic         sumMatch
);
  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (!sumValid && sumOut == '0));
  // R4
  capture_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finalize && !clr) |=> sumValid);
  // R5
  no_all_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> (sumOut != {W{1'b1}}));
  // R7
  not_computed_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sumValid && rxSum == {W{1'b1}}) |-> sumMatch);
  // R6
  no_match_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sumValid |-> !sumMatch);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!finalize && !clr) |=> $stable(sumOut));
  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sumValid && !clr && !wordValid) |=> sumValid);
endmodule

bind rotsum_unit rotsum_unit_chk #(.W(W)) i_chk (
  .clk(clk), .rstN(rstN), .clr(clr), .wordValid(wordValid), .finalize(finalize),
  .rxSum(rxSum), .sumOut(sumOut), .sumValid(sumValid), .sumMatch(sumMatch)
);

// File: tb/test_rotsum_unit.sv
module test_rotsum_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clr = 1'b0, wordValid = 1'b0, finalize = 1'b0;
  logic [15:0] wordIn = '0, rxSum = '0;
  logic [15:0] sumOut, sumOutAlt;
  logic sumValid, sumMatch, validAlt, matchAlt;
  int total = 0, bad = 0;
  logic [15:0] mAcc = '0, mOut = '0;
  logic mValid = 1'b0;

  always #5 clk = ~clk;

  rotsum_unit #(.W(16), .ROTATE_FIRST(1'b0)) i_rotsum_unit (
    .clk(clk), .rstN(rstN), .clr(clr), .wordValid(wordValid), .wordIn(wordIn),
    .finalize(finalize), .rxSum(rxSum), .sumOut(sumOut), .sumValid(sumValid),
    .sumMatch(sumMatch));

  rotsum_unit #(.W(16), .ROTATE_FIRST(1'b1)) i_rotsum_unit_alt (
    .clk(clk), .rstN(rstN), .clr(clr), .wordValid(wordValid), .wordIn(wordIn),
    .finalize(finalize), .rxSum(rxSum), .sumOut(sumOutAlt), .sumValid(validAlt),
    .sumMatch(matchAlt));

  function automatic logic [15:0] refStep(logic [15:0] a, logic [15:0] w);
    logic [31:0] s;
    s = {16'h0, a} + {16'h0, w};
    s = (s & 32'hFFFF) + (s >> 16);
    s = ((s << 1) | (s >> 15)) & 32'hFFFF;
    return s[15:0];
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic refMatch(logic [15:0] rx);
    return mValid && (rx == 16'hFFFF || rx == mOut);
  endfunction

  // called at a negedge; applies inputs, advances one edge, returns at next negedge
  task automatic step(logic c, logic v, logic [15:0] w, logic f);
    logic [15:0] after;
    clr = c; wordValid = v; wordIn = w; finalize = f;
    @(posedge clk);
    if (c) begin
      mAcc = '0; mOut = '0; mValid = 1'b0;
    end else begin
      after = v ? refStep(mAcc, w) : mAcc;
      mAcc = after;
      if (f) begin
        mOut = (after == 16'hFFFF) ? 16'h0 : after;
        mValid = 1'b1;
      end else if (v) mValid = 1'b0;
    end
    @(negedge clk);
    clr = 1'b0; wordValid = 1'b0; finalize = 1'b0;
  endtask

  task automatic checkAll(string req);
    chk(req, sumOut, mOut);
    chk(req, {15'h0, sumValid}, {15'h0, mValid});
    chk(req, {15'h0, sumMatch}, {15'h0, refMatch(rxSum)});
    chk("R9", sumOut, sumOutAlt);
    chk("R9", {14'h0, validAlt, matchAlt}, {14'h0, sumValid, sumMatch});
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", sumOut, 16'h0);
    chk("R1", {15'h0, sumValid}, 16'h0);
    step(0, 0, 0, 1);
    chk("R1", sumOut, 16'h0);
    chk("R1", {15'h0, sumValid}, 16'h1);
    // R2 single word: 0x8000 -> rotl -> 0x0001
    step(1, 0, 0, 0);
    step(0, 1, 16'h8000, 1);
    chk("R2", sumOut, 16'h0001);
    // R2 end-around carry: 8001 -> 0003; +FFFE -> 0002 -> 0004
    step(1, 0, 0, 0);
    step(0, 1, 16'h8001, 0);
    step(0, 1, 16'hFFFE, 0);
    chk("R10", {15'h0, sumValid}, 16'h0);
    step(0, 0, 0, 1);
    chk("R2", sumOut, 16'h0004);
    // R6 match / mismatch, R7 forced match
    rxSum = 16'h0004; #1;
    chk("R6", {15'h0, sumMatch}, 16'h1);
    rxSum = 16'h0005; #1;
    chk("R6", {15'h0, sumMatch}, 16'h0);
    rxSum = 16'hFFFF; #1;
    chk("R7", {15'h0, sumMatch}, 16'h1);
    // R5 all ones mapped to zero
    step(1, 0, 0, 0);
    step(0, 1, 16'hFFFF, 1);
    chk("R5", sumOut, 16'h0000);
    chk("R5", {15'h0, sumValid}, 16'h1);
    // R8 clear overrides word and finalize
    step(1, 1, 16'h1234, 1);
    chk("R8", {15'h0, sumValid}, 16'h0);
    chk("R8", sumOut, 16'h0);
    step(0, 0, 0, 1);
    chk("R8", sumOut, 16'h0);
    // R3 back-to-back words, R4 finalize with last word
    step(1, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 1, 16'h1111 * i[15:0] + 16'h0F0F, (i == 7));
    checkAll("R3");
    // R10 hold with no strobes
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 16'hABCD, 0);
      checkAll("R10");
    end
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      rxSum = (r[7:6] == 2'b00) ? 16'hFFFF : (r[7:6] == 2'b01 ? mOut : 16'($urandom));
      step(r[5:0] == 6'h0, r[2:0] != 3'h0, 16'($urandom), r[5:3] == 3'h7);
      checkAll("R4");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule